// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block supplies the low address bits for a four-beat burst into a synchronous memory. On a clock edge where either of two active-low address strobes is asserted and the select qualifier is high, it captures the external address as the burst base. It then steps its two-bit beat count once on every edge where the active-low advance input is asserted. If advance is high, the address does not change, and this inserts a wait state.

A static order input selects how the low bits follow the base. In interleaved order, the low bits are the base XOR the beat count. In linear order, the low bits are the base plus the beat count, wrapping modulo four. The bits above the low field come from the captured address and do not change for the whole burst. The output is taken from registers. It changes in the cycle after the edge that loads or steps the counter.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, and after it is released with no further stimulus, addr_o is 0.
- R2: On an edge where strobe_proc_ni or strobe_ctrl_ni is 0 and sel_i is 1, the block loads the base. After that edge, addr_o equals the addr_i sampled at the edge, and the beat count is 0.
- R3: On an edge where a strobe is 0 but sel_i is 0, the strobe is ignored and addr_o does not change, even when adv_ni is 0.
- R4: On an edge where both strobes are 1 and adv_ni is 0, the beat count increases by one.
- R5: On an edge where both strobes are 1 and adv_ni is 1, addr_o holds its value.
- R6: With mode_i = 1 (interleaved), the low two bits of addr_o are the base low bits XOR the beat count.
- R7: With mode_i = 0 (linear), the low two bits of addr_o are (base low bits + beat count) mod 4.
- R8: After the fourth beat, one more advance wraps the count to 0 and addr_o returns to the base. The count does not stop.
- R9: A selected strobe during a burst reloads the base and restarts the count at 0. A selected strobe wins over adv_ni = 0 on the same edge.
- R10: Between loads, the bits of addr_o above the low two stay equal to those of the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_proc_ni | input | 1 | Processor-side address strobe, active low |
| strobe_ctrl_ni | input | 1 | Controller-side address strobe, active low |
| sel_i | input | 1 | Select qualifier; a strobe only loads when it is 1 |
| adv_ni | input | 1 | Burst advance, active low |
| mode_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_i | input | ADDR_W | External address |
| addr_o | output | ADDR_W | Burst address: loaded upper bits and sequenced low bits |

## Verification
A load and an advance can be requested on the same edge. The bench provokes this in the middle of a burst by asserting a selected strobe together with adv_ni low. It expects the new base with count 0, not an advanced address. A second overlap is an unselected strobe together with adv_ni low. Here the bench expects addr_o unchanged, which shows that the strobe blocks the step even though it does not load.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } order_e;
endpackage

// File: rtl/burst_ctl.sv
module burst_ctl (
  input  logic strobe_proc_ni,
  input  logic strobe_ctrl_ni,
  input  logic sel_i,
  input  logic adv_ni,
  output logic load_o,
  output logic step_o
);
  logic any_strobe;
  assign any_strobe = ~strobe_proc_ni | ~strobe_ctrl_ni;
  assign load_o     = any_strobe & sel_i;
  // any strobe, selected or not, blocks stepping
  assign step_o     = ~adv_ni & ~any_strobe;
endmodule

// File: rtl/burst_cnt.sv
module burst_cnt #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      cnt_o  <= '0;
    end else if (load_i) begin
      base_o <= addr_i;
      cnt_o  <= '0;
    end else if (step_i) begin
      cnt_o  <= cnt_o + 1'b1;
    end
  end

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == '0);
  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> ($stable(cnt_o) && $stable(base_o)));
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int CNT_W = 2
) (
  input  burst_pkg::order_e order_i,
  input  logic [CNT_W-1:0]  base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  lo_o
);
  always_comb begin
    unique case (order_i)
      burst_pkg::ORD_INTERLEAVED: lo_o = base_i ^ cnt_i;
      default:                    lo_o = base_i + cnt_i;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_proc_ni,
  input  logic              strobe_ctrl_ni,
  input  logic              sel_i,
  input  logic              adv_ni,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int CNT_W = 2;

  logic              load, step;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  cnt, lo;
  burst_pkg::order_e order;

  assign order = burst_pkg::order_e'(mode_i);

  burst_ctl u_ctl (
    .strobe_proc_ni(strobe_proc_ni), .strobe_ctrl_ni(strobe_ctrl_ni),
    .sel_i(sel_i), .adv_ni(adv_ni), .load_o(load), .step_o(step)
  );

  burst_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .addr_i(addr_i), .base_o(base), .cnt_o(cnt)
  );

  burst_seq #(.CNT_W(CNT_W)) u_seq (
    .order_i(order), .base_i(base[CNT_W-1:0]), .cnt_i(cnt), .lo_o(lo)
  );

  assign addr_o = {base[ADDR_W-1:CNT_W], lo};

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && (!strobe_proc_ni || !strobe_ctrl_ni)) |=> addr_o == $past(addr_i));
  assert_unselected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && (!strobe_proc_ni || !strobe_ctrl_ni) && $stable(mode_i)) |=> $stable(addr_o));
  assert_upper_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && (!strobe_proc_ni || !strobe_ctrl_ni)) |=> $stable(addr_o[ADDR_W-1:CNT_W]));
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          sp_n = 1'b1, sc_n = 1'b1, sel = 1'b0, adv_n = 1'b1, mode = 1'b0;
  logic [AW-1:0] a = '0;
  logic [AW-1:0] q;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .strobe_proc_ni(sp_n), .strobe_ctrl_ni(sc_n),
    .sel_i(sel), .adv_ni(adv_n), .mode_i(mode), .addr_i(a), .addr_o(q)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] base, int beat, logic m);
    logic [1:0] lo;
    lo = m ? (base[1:0] ^ 2'(beat)) : 2'(base[1:0] + 2'(beat));
    return {base[AW-1:2], lo};
  endfunction

  task automatic chk(string req, logic [AW-1:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: addr_o=%h expected %h", req, q, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the following posedge
  task automatic cyc(logic p_n, logic c_n, logic s, logic v_n, logic [AW-1:0] ad);
    @(negedge clk);
    sp_n = p_n; sc_n = c_n; sel = s; adv_n = v_n; a = ad;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    #1 chk("R1", '0);
    @(negedge clk) rst_n = 1'b1;
    cyc(1, 1, 0, 1, 16'hFFFF);
    chk("R1", '0);
  endtask

  task automatic t_interleaved;
    logic [AW-1:0] b = 16'hA5C1;
    mode = 1'b1;
    cyc(0, 1, 1, 1, b);
    chk("R2", b);
    for (int k = 1; k < 4; k++) begin
      cyc(1, 1, 0, 0, 16'h0000);
      chk("R6", expect_addr(b, k, 1'b1));
      chk("R10", expect_addr(b, k, 1'b1));
    end
    cyc(1, 1, 0, 0, 16'h0000);
    chk("R8", b);
  endtask

  task automatic t_linear;
    logic [AW-1:0] b = 16'h3C07;
    mode = 1'b0;
    cyc(1, 0, 1, 1, b);
    chk("R2", b);
    for (int k = 1; k < 4; k++) begin
      cyc(1, 1, 1, 0, 16'h1234);
      chk("R7", expect_addr(b, k, 1'b0));
    end
    cyc(1, 1, 1, 0, 16'h1234);
    chk("R8", b);
  endtask

  task automatic t_wait;
    logic [AW-1:0] b = 16'h0002;
    mode = 1'b0;
    cyc(0, 1, 1, 0, b);
    cyc(1, 1, 0, 0, '0);
    chk("R4", expect_addr(b, 1, 1'b0));
    cyc(1, 1, 0, 1, '0);
    chk("R5", expect_addr(b, 1, 1'b0));
    cyc(1, 1, 1, 1, 16'hFFFF);
    chk("R5", expect_addr(b, 1, 1'b0));
    cyc(1, 1, 0, 0, '0);
    chk("R4", expect_addr(b, 2, 1'b0));
  endtask

  task automatic t_unselected;
    logic [AW-1:0] b = 16'h7001;
    mode = 1'b1;
    cyc(0, 1, 1, 1, b);
    cyc(1, 1, 0, 0, '0);
    cyc(0, 1, 0, 0, 16'hBEEE);
    chk("R3", expect_addr(b, 1, 1'b1));
    cyc(1, 0, 0, 0, 16'hBEEF);
    chk("R3", expect_addr(b, 1, 1'b1));
  endtask

  task automatic t_restart;
    logic [AW-1:0] b1 = 16'h1111, b2 = 16'h8883;
    mode = 1'b1;
    cyc(1, 0, 1, 1, b1);
    cyc(1, 1, 0, 0, '0);
    cyc(1, 1, 0, 0, '0);
    chk("R6", expect_addr(b1, 2, 1'b1));
    cyc(0, 0, 1, 0, b2);
    chk("R9", b2);
    cyc(1, 1, 0, 0, '0);
    chk("R9", expect_addr(b2, 1, 1'b1));
    chk("R10", {b2[AW-1:2], q[1:0]});
  endtask

  initial begin
    t_reset();
    t_interleaved();
    t_linear();
    t_wait();
    t_unselected();
    t_restart();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule